// File: doc/BRIEF.md
# Pipeline Synchronization Barrier Controller

This block holds the issue stage of a simple in-order core while a synchronizing barrier drains. The decode stage offers an instruction through a valid/ready handshake along with a 3-bit opcode. The block sorts each opcode into one of three classes: not a barrier, memory barrier, or instruction-sync barrier. The two memory-barrier forms, the I/O ordering barrier and the full synchronize, share one execution-synchronizing path. That path first waits for every earlier instruction to retire. It then waits until no local storage access is outstanding and the bus acknowledges.

The instruction-sync barrier waits only for earlier instructions to retire. It then pulses a flush of the prefetch buffer, so that fetching restarts in the context the earlier instructions set up. It does not wait on storage accesses or on the bus.

Work in flight is given to the block as two counts and an acknowledge line. The block drives an issue stall, a one-cycle prefetch flush and a one-cycle completion strobe. While a barrier is being processed, ready is low, so barriers run strictly one after another.

Top module: `bar_sync_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `issue_stall`, `pf_flush` and `bar_done` are low and `dec_ready` is high.
- R2: Opcodes with bit 2 clear are not barriers. Offering one, or offering any opcode with `dec_valid` low, raises no stall and starts no barrier.
- R3: `issue_stall` rises combinationally in the cycle a barrier is accepted (`dec_valid` and `dec_ready` high, opcode bit 2 set). It stays high until the cycle in which `bar_done` pulses, and it is low in that cycle unless a new barrier is accepted in it.
- R4: Both barrier classes stay in the instruction-drain phase for as long as `inflight_cnt` is nonzero. The phase lasts at least one cycle.
- R5: A memory barrier completes only after the instruction-drain phase, and only once a cycle has seen `mem_pend_cnt` equal to zero with `bus_ack` high. It never completes while accesses are still outstanding.
- R6: Opcodes 3'b100 (I/O ordering), 3'b101 and 3'b110 (full synchronize) follow an identical sequence and latency. When every count is already zero and the acknowledge is high, `bar_done` pulses four cycles after acceptance.
- R7: Opcode 3'b111 (instruction sync) raises `pf_flush` for exactly one cycle. That cycle is the first cycle after the instruction drain ends, and `bar_done` follows two cycles later. `mem_pend_cnt` and `bus_ack` have no effect on it.
- R8: `pf_flush` never rises for a memory barrier.
- R9: `dec_ready` is low from the cycle after acceptance until the cycle of `bar_done`. A barrier offered in that window is not taken, and one held until `bar_done` is taken in that cycle.
- R10: `bar_done` is high for exactly one cycle per barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_op | input | 3 | Opcode: bit 2 marks a barrier; 00 I/O ordering, 01/10 full synchronize, 11 instruction sync |
| dec_ready | output | 1 | Block can take a barrier |
| inflight_cnt | input | CNT_W | Earlier instructions not yet retired |
| mem_pend_cnt | input | CNT_W | Local storage accesses still outstanding |
| bus_ack | input | 1 | Bus reports earlier accesses visible |
| issue_stall | output | 1 | Holds the issue stage |
| pf_flush | output | 1 | One-cycle prefetch-buffer discard |
| bar_done | output | 1 | One-cycle barrier completion strobe |

## Verification
The bench sweeps every barrier opcode against every timing at which the instruction count, the access count and the acknowledge clear. It computes the completion cycle arithmetically from the three clear times. A design that let the full synchronize take a longer path than the I/O barrier, or that completed a memory barrier while an access was outstanding, would strobe in the wrong cycle. So would an instruction sync that waited on the access count or the acknowledge, since the bench keeps both busy well past its expected completion. The bench also holds a second barrier at the handshake during a drain. A design that took it early, dropped it, or failed to take it back-to-back in the completion cycle would show a misplaced stall or flush.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN_EXEC,
    ST_DRAIN_MEM,
    ST_FLUSH,
    ST_DONE
  } bar_state_e;

  typedef enum logic [1:0] {
    BC_NONE,
    BC_MEM,
    BC_ISYNC
  } bar_class_e;

  // bit 2 marks a barrier; low bits 11 select instruction sync,
  // every other barrier encoding shares the memory path
  function automatic bar_class_e op_class(input logic [OP_W-1:0] op);
    if (!op[OP_W-1])           return BC_NONE;
    else if (op[1:0] == 2'b11) return BC_ISYNC;
    else                       return BC_MEM;
  endfunction

  function automatic logic cnt_is_zero(input logic [15:0] cnt);
    return cnt == '0;
  endfunction
endpackage

// File: rtl/bar_decode.sv
module bar_decode
  import bar_pkg::*;
(
  input  logic            dec_valid,
  input  logic [OP_W-1:0] dec_op,
  input  logic            idle,
  output logic            accept,
  output bar_class_e      acc_class
);
  bar_class_e cls;

  always_comb begin
    cls       = op_class(dec_op);
    accept    = dec_valid && idle && (cls != BC_NONE);
    acc_class = cls;
  end
endmodule

// File: rtl/bar_drain_mon.sv
module bar_drain_mon #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic [CNT_W-1:0] mem_pend_cnt,
  input  logic             bus_ack,
  output logic             exec_clear,
  output logic             mem_clear
);
  localparam int PAD = 16 - CNT_W;

  always_comb begin
    exec_clear = bar_pkg::cnt_is_zero({{PAD{1'b0}}, inflight_cnt});
    mem_clear  = bar_pkg::cnt_is_zero({{PAD{1'b0}}, mem_pend_cnt}) && bus_ack;
  end
endmodule

// File: rtl/bar_fsm.sv
module bar_fsm
  import bar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  bar_class_e acc_class,
  input  logic       exec_clear,
  input  logic       mem_clear,
  output bar_state_e st,
  output bar_class_e cls_q,
  output logic       idle,
  output logic       pf_flush,
  output logic       done_q
);
  bar_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:       if (accept) nxt = ST_DRAIN_EXEC;
      ST_DRAIN_EXEC: if (exec_clear)
                       nxt = (cls_q == BC_ISYNC) ? ST_FLUSH : ST_DRAIN_MEM;
      ST_DRAIN_MEM:  if (mem_clear) nxt = ST_DONE;
      ST_FLUSH:      nxt = ST_DONE;
      ST_DONE:       nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cls_q  <= BC_NONE;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (st == ST_DONE);
      if (accept) cls_q <= acc_class;
    end
  end

  assign idle     = (st == ST_IDLE);
  assign pf_flush = (st == ST_FLUSH);
endmodule

// File: rtl/bar_sync_ctrl.sv
module bar_sync_ctrl
  import bar_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_op,
  output logic             dec_ready,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic [CNT_W-1:0] mem_pend_cnt,
  input  logic             bus_ack,
  output logic             issue_stall,
  output logic             pf_flush,
  output logic             bar_done
);
  logic       accept;
  bar_class_e acc_class;
  logic       exec_clear;
  logic       mem_clear;
  bar_state_e st;
  bar_class_e cls_q;
  logic       idle;
  logic       busy;

  bar_decode u_dec (
    .dec_valid (dec_valid),
    .dec_op    (dec_op),
    .idle      (idle),
    .accept    (accept),
    .acc_class (acc_class)
  );

  bar_drain_mon #(.CNT_W(CNT_W)) u_mon (
    .inflight_cnt (inflight_cnt),
    .mem_pend_cnt (mem_pend_cnt),
    .bus_ack      (bus_ack),
    .exec_clear   (exec_clear),
    .mem_clear    (mem_clear)
  );

  bar_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .acc_class  (acc_class),
    .exec_clear (exec_clear),
    .mem_clear  (mem_clear),
    .st         (st),
    .cls_q      (cls_q),
    .idle       (idle),
    .pf_flush   (pf_flush),
    .done_q     (bar_done)
  );

  assign busy        = !idle;
  assign dec_ready   = idle;
  assign issue_stall = busy || accept;
endmodule

// File: rtl/bar_sync_chk.sv
module bar_sync_chk
  import bar_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_ready,
  input logic             issue_stall,
  input logic             pf_flush,
  input logic             bar_done,
  input logic [CNT_W-1:0] inflight_cnt,
  input logic [CNT_W-1:0] mem_pend_cnt,
  input logic             bus_ack,
  input logic             accept,
  input logic             busy,
  input bar_state_e       st,
  input bar_class_e       cls_q
);
  // R3
  stall_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> issue_stall);
  // R3
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> issue_stall);
  // R4
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN_EXEC && inflight_cnt != '0) |=> st == ST_DRAIN_EXEC);
  // R5
  mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && cls_q == BC_MEM) |->
      ($past(mem_pend_cnt) == '0 && $past(bus_ack)));
  // R7
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flush |=> !pf_flush);
  // R8
  flush_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flush |-> cls_q == BC_ISYNC);
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dec_ready);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);
  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_done) |-> $past(st) == ST_DONE);
endmodule

bind bar_sync_ctrl bar_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_ready    (dec_ready),
  .issue_stall  (issue_stall),
  .pf_flush     (pf_flush),
  .bar_done     (bar_done),
  .inflight_cnt (inflight_cnt),
  .mem_pend_cnt (mem_pend_cnt),
  .bus_ack      (bus_ack),
  .accept       (accept),
  .busy         (busy),
  .st           (st),
  .cls_q        (cls_q)
);

// File: tb/bar_sync_ctrl_tb.sv
module bar_sync_ctrl_tb;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dec_valid = 1'b0;
  logic [2:0]       dec_op = '0;
  logic             dec_ready;
  logic [CNT_W-1:0] inflight_cnt = '0;
  logic [CNT_W-1:0] mem_pend_cnt = '0;
  logic             bus_ack = 1'b1;
  logic             issue_stall;
  logic             pf_flush;
  logic             bar_done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bar_sync_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_ready(dec_ready), .inflight_cnt(inflight_cnt),
    .mem_pend_cnt(mem_pend_cnt), .bus_ack(bus_ack),
    .issue_stall(issue_stall), .pf_flush(pf_flush), .bar_done(bar_done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // One barrier: instruction count clears from cycle ez, access count from
  // cycle mz, acknowledge high from cycle az; cycle 0 is acceptance.
  task automatic run_bar(input logic [2:0] op, input int ez, input int mz,
                         input int az, input bit hold);
    int x, c, dn, fl;
    bit is_is;
    is_is = (op == 3'b111);
    x  = (ez < 1) ? 1 : ez;
    c  = x + 1;
    if (mz > c) c = mz;
    if (az > c) c = az;
    fl = x + 1;
    dn = is_is ? x + 3 : c + 2;
    for (int k = 0; k <= dn; k++) begin
      @(negedge clk);
      dec_valid    = (k == 0) || hold;
      dec_op       = (k == 0) ? op : 3'b111;
      inflight_cnt = (k < ez) ? 4'd3 : 4'd0;
      mem_pend_cnt = (k < mz) ? 4'd5 : 4'd0;
      bus_ack      = (k >= az);
      #1;
      chk("R3 stall", issue_stall, (k < dn) || (k == dn && hold));
      chk("R9 ready", dec_ready, (k == 0) || (k == dn));
      chk(is_is ? "R7 flush" : "R8 flush", pf_flush, is_is && k == fl);
      if (is_is)        chk("R7 done", bar_done, k == dn);
      else if (ez > 1)  chk("R4 done", bar_done, k == dn);
      else if (mz > 2 || az > 2) chk("R5 done", bar_done, k == dn);
      else              chk("R6 done", bar_done, k == dn);
    end
    if (!hold) begin
      @(negedge clk);
      dec_valid = 1'b0;
      #1;
      chk("R10 done", bar_done, 1'b0);
      chk("R3 stall", issue_stall, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 stall", issue_stall, 1'b0);
    chk("R1 ready", dec_ready, 1'b1);
    chk("R1 flush", pf_flush, 1'b0);
    chk("R1 done", bar_done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 done", bar_done, 1'b0);
    chk("R1 ready", dec_ready, 1'b1);

    // R2 non-barrier opcodes and an unasserted valid
    for (int op = 0; op < 4; op++) begin
      @(negedge clk);
      dec_valid = 1'b1; dec_op = 3'(op); #1;
      chk("R2 stall", issue_stall, 1'b0);
      chk("R2 ready", dec_ready, 1'b1);
      @(negedge clk);
      dec_valid = 1'b0; #1;
      chk("R2 stall", issue_stall, 1'b0);
      chk("R2 done", bar_done, 1'b0);
    end
    @(negedge clk);
    dec_valid = 1'b0; dec_op = 3'b101; #1;
    chk("R2 stall", issue_stall, 1'b0);
    @(negedge clk); #1;
    chk("R2 stall", issue_stall, 1'b0);

    // R4 R5 R6 R7 R8 sweep over opcode and clear times
    for (int op = 4; op < 8; op++)
      for (int ez = 0; ez < 4; ez++)
        for (int mz = 0; mz < 5; mz++)
          for (int az = 0; az < 5; az++)
            run_bar(3'(op), ez, mz, az, 1'b0);

    // R7 instruction sync ignores a long-busy access count and acknowledge
    run_bar(3'b111, 2, 30, 30, 1'b0);

    // R9 barrier held during a memory drain, taken back-to-back at done
    run_bar(3'b101, 3, 4, 2, 1'b1);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      dec_valid = 1'b0; inflight_cnt = '0; mem_pend_cnt = '0; bus_ack = 1'b1;
      #1;
      chk("R9 stall", issue_stall, j < 4);
      chk("R9 flush", pf_flush, j == 2);
      chk("R9 done", bar_done, j == 4);
    end
    @(negedge clk); #1;
    chk("R10 done", bar_done, 1'b0);

    finish_run();
  end
endmodule